// File: doc/BRIEF.md
# Register-Reference Execute Unit

This block performs the register-type operations of a small accumulator machine during the execute phase. The control path decodes a register-class instruction and presents its twelve low instruction bits together with the current 16-bit accumulator and the one-bit extend flag. One strobe cycle later, the block returns the new accumulator and extend values. It also raises either a one-cycle skip request, which the program counter logic turns into an extra increment, or a one-cycle halt request, which clears the machine's run flip-flop.

Each of the twelve selector bits names one operation. The operations are: clearing or complementing the accumulator or the extend flag; rotating the accumulator one place through the extend flag in either direction; incrementing the accumulator; four conditional skips; and halt. If more than one selector bit is set, only the highest-numbered one is executed. All results are registered. Reset is synchronous and active-high.

Top module: `regref_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs become zero after that edge.
- R2: With `en` high and selector bit 11 winning, `acc_out` is zero after the next edge and `ext_out` equals `ext_in`.
- R3: Bit 10 clears the extend flag and bit 8 complements it. In both cases `acc_out` equals `acc_in`.
- R4: Bit 9 gives `acc_out` = bitwise NOT of `acc_in`, with the extend flag unchanged.
- R5: Bit 7 rotates right through the extend flag: `acc_out` = {`ext_in`, `acc_in[15:1]`} and `ext_out` = `acc_in[0]`.
- R6: Bit 6 rotates left through the extend flag: `acc_out` = {`acc_in[14:0]`, `ext_in`} and `ext_out` = `acc_in[15]`.
- R7: Bit 5 gives `acc_out` = `acc_in` + 1 modulo 2^16, with the extend flag unchanged. 0xFFFF wraps to 0x0000.
- R8: Bits 4, 3, 2 and 1 each pulse `skip_pulse` for one cycle when their condition holds on the inputs. The conditions are: bit 4, `acc_in[15]`=0; bit 3, `acc_in[15]`=1; bit 2, `acc_in`=0; bit 1, `ext_in`=0. Accumulator and extend pass through unchanged.
- R9: Bit 0 pulses `halt_pulse` for one cycle, with data passing through. `skip_pulse` and `halt_pulse` are never high together.
- R10: When several selector bits are set, only the highest-numbered one takes effect.
- R11: A cycle with `en` low leaves `acc_out` and `ext_out` unchanged and both pulses low. A cycle with `en` high and all selector bits zero copies the inputs through and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execute strobe for one operation |
| op_bits | input | 12 | Low instruction bits, one operation per bit |
| acc_in | input | 16 | Current accumulator |
| ext_in | input | 1 | Current extend flag |
| acc_out | output | 16 | New accumulator (registered) |
| ext_out | output | 1 | New extend flag (registered) |
| skip_pulse | output | 1 | One-cycle request to skip the next instruction |
| halt_pulse | output | 1 | One-cycle request to stop the machine |

## Verification
Directed single-bit selectors are run on accumulator values 0x0000, 0x8000, 0x0001 and 0xFFFF with both extend values. This separates each rotate's fill and spill bits, shows the increment wrap, and gives each skip condition both its true and false outcome. Random multi-bit selectors show that the highest set bit decides the result and that lower bits are ignored. Idle cycles with random inputs show the held outputs. An all-zero selector shows the pass-through case.

// File: rtl/regref_pkg.sv
package regref_pkg;
  // Selector bit positions; the ordering is also the priority (higher wins).
  typedef enum int unsigned {
    POS_HALT     = 0,
    POS_SKIP_EZ  = 1,
    POS_SKIP_AZ  = 2,
    POS_SKIP_NEG = 3,
    POS_SKIP_POS = 4,
    POS_INC      = 5,
    POS_ROL      = 6,
    POS_ROR      = 7,
    POS_NOT_E    = 8,
    POS_NOT_A    = 9,
    POS_CLR_E    = 10,
    POS_CLR_A    = 11
  } op_pos_e;

  localparam int unsigned NUM_OPS = 12;
endpackage

// File: rtl/regref_prio.sv
module regref_prio #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  for (genvar i = 0; i < W; i++) begin : g_pri
    if (i == W - 1) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_low
      assign grant[i] = req[i] & ~(|req[W-1:i+1]);
    end
  end
endmodule

// File: rtl/regref_cond.sv
module regref_cond #(
  parameter int unsigned DW = 16
) (
  input  logic [11:0]   grant,
  input  logic [DW-1:0] acc,
  input  logic          ext,
  output logic          skip,
  output logic          halt
);
  import regref_pkg::*;

  logic sign_bit;
  logic acc_zero;

  assign sign_bit = acc[DW-1];
  assign acc_zero = (acc == '0);

  always_comb begin
    skip = 1'b0;
    if (grant[POS_SKIP_POS] && !sign_bit) skip = 1'b1;
    if (grant[POS_SKIP_NEG] &&  sign_bit) skip = 1'b1;
    if (grant[POS_SKIP_AZ]  &&  acc_zero) skip = 1'b1;
    if (grant[POS_SKIP_EZ]  && !ext)      skip = 1'b1;
    halt = grant[POS_HALT];
  end
endmodule

// File: rtl/regref_alu.sv
module regref_alu #(
  parameter int unsigned DW = 16
) (
  input  logic [11:0]   grant,
  input  logic [DW-1:0] acc,
  input  logic          ext,
  output logic [DW-1:0] acc_nx,
  output logic          ext_nx
);
  import regref_pkg::*;

  always_comb begin
    acc_nx = acc;
    ext_nx = ext;
    if (grant[POS_CLR_A]) acc_nx = '0;
    if (grant[POS_CLR_E]) ext_nx = 1'b0;
    if (grant[POS_NOT_A]) acc_nx = ~acc;
    if (grant[POS_NOT_E]) ext_nx = ~ext;
    if (grant[POS_ROR]) begin
      acc_nx = {ext, acc[DW-1:1]};
      ext_nx = acc[0];
    end
    if (grant[POS_ROL]) begin
      acc_nx = {acc[DW-2:0], ext};
      ext_nx = acc[DW-1];
    end
    if (grant[POS_INC]) acc_nx = acc + 1'b1;
  end
endmodule

// File: rtl/regref_exec_unit.sv
module regref_exec_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SEL_W-1:0]  op_bits,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              ext_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              ext_out,
  output logic              skip_pulse,
  output logic              halt_pulse
);
  import regref_pkg::*;

  localparam int unsigned OPS = NUM_OPS;

  logic [OPS-1:0]    req;
  logic [OPS-1:0]    grant;
  logic [DATA_W-1:0] acc_nx;
  logic              ext_nx;
  logic              skip_nx;
  logic              halt_nx;

  assign req = OPS'(op_bits);

  regref_prio #(.W(OPS)) u_prio (
    .req   (req),
    .grant (grant)
  );

  regref_alu #(.DW(DATA_W)) u_alu (
    .grant  (grant),
    .acc    (acc_in),
    .ext    (ext_in),
    .acc_nx (acc_nx),
    .ext_nx (ext_nx)
  );

  regref_cond #(.DW(DATA_W)) u_cond (
    .grant (grant),
    .acc   (acc_in),
    .ext   (ext_in),
    .skip  (skip_nx),
    .halt  (halt_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out    <= '0;
      ext_out    <= 1'b0;
      skip_pulse <= 1'b0;
      halt_pulse <= 1'b0;
    end else begin
      skip_pulse <= en & skip_nx;
      halt_pulse <= en & halt_nx;
      if (en) begin
        acc_out <= acc_nx;
        ext_out <= ext_nx;
      end
    end
  end
endmodule

// File: rtl/regref_exec_sva.sv
module regref_exec_sva #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [SEL_W-1:0]  op_bits,
  input logic [DATA_W-1:0] acc_in,
  input logic              ext_in,
  input logic [DATA_W-1:0] acc_out,
  input logic              ext_out,
  input logic              skip_pulse,
  input logic              halt_pulse
);
  // R9: skip and halt exclusive
  a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({skip_pulse, halt_pulse}));

  // R11: idle cycle holds data and keeps pulses low
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!skip_pulse && !halt_pulse && $stable(acc_out) && $stable(ext_out)));

  // R2: top-priority clear of accumulator
  a_r2_clear_acc: assert property (@(posedge clk) disable iff (rst)
    (en && op_bits[11]) |=> (acc_out == '0 && ext_out == $past(ext_in)));

  // R9: lone bit 0 raises halt
  a_r9_halt_lone: assert property (@(posedge clk) disable iff (rst)
    (en && op_bits == SEL_W'(1)) |=> halt_pulse);

  // R10: a winning data operation (bits 11..5) never produces a pulse
  a_r10_no_pulse_for_data_op: assert property (@(posedge clk) disable iff (rst)
    (en && (|op_bits[11:5])) |=> (!skip_pulse && !halt_pulse));

  // R7: lone increment winner wraps modulo 2^DATA_W
  a_r7_increment: assert property (@(posedge clk) disable iff (rst)
    (en && op_bits[11:5] == 7'b0000001) |=> (acc_out == DATA_W'($past(acc_in) + 1'b1)));
endmodule

bind regref_exec_unit regref_exec_sva #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .op_bits    (op_bits),
  .acc_in     (acc_in),
  .ext_in     (ext_in),
  .acc_out    (acc_out),
  .ext_out    (ext_out),
  .skip_pulse (skip_pulse),
  .halt_pulse (halt_pulse)
);

// File: tb/regref_exec_unit_tb.sv
module regref_exec_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [11:0] op_bits = '0;
  logic [15:0] acc_in = '0;
  logic        ext_in = 1'b0;
  logic [15:0] acc_out;
  logic        ext_out;
  logic        skip_pulse;
  logic        halt_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_acc = '0;
  logic        m_ext = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regref_exec_unit u_dut (
    .clk(clk), .rst(rst), .en(en), .op_bits(op_bits),
    .acc_in(acc_in), .ext_in(ext_in), .acc_out(acc_out),
    .ext_out(ext_out), .skip_pulse(skip_pulse), .halt_pulse(halt_pulse)
  );

  function automatic int win_bit(input logic [11:0] op);
    for (int i = 11; i >= 0; i--) if (op[i]) return i;
    return -1;
  endfunction

  function automatic string tag_of(input logic [11:0] op, input logic e);
    int w;
    w = win_bit(op);
    if (!e) return "R11";
    if ($countones(op) > 1) return "R10";
    case (w)
      11: return "R2";
      10, 8: return "R3";
      9: return "R4";
      7: return "R5";
      6: return "R6";
      5: return "R7";
      4, 3, 2, 1: return "R8";
      0: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Expected result: {acc, ext, skip, halt}
  function automatic logic [18:0] model(input logic e, input logic [11:0] op,
                                        input logic [15:0] a, input logic x,
                                        input logic [15:0] pa, input logic px);
    logic [15:0] na; logic nx, sk, hl;
    if (!e) return {pa, px, 2'b00};
    na = a; nx = x; sk = 1'b0; hl = 1'b0;
    case (win_bit(op))
      11: na = 16'h0000;
      10: nx = 1'b0;
      9:  na = ~a;
      8:  nx = ~x;
      7:  begin na = {x, a[15:1]}; nx = a[0]; end
      6:  begin na = {a[14:0], x}; nx = a[15]; end
      5:  na = a + 16'h0001;
      4:  sk = ~a[15];
      3:  sk = a[15];
      2:  sk = (a == 16'h0000);
      1:  sk = ~x;
      0:  hl = 1'b1;
      default: ;
    endcase
    return {na, nx, sk, hl};
  endfunction

  task automatic step(input logic e, input logic [11:0] op,
                      input logic [15:0] a, input logic x);
    logic [18:0] exp_v;
    string t;
    en = e; op_bits = op; acc_in = a; ext_in = x;
    exp_v = model(e, op, a, x, m_acc, m_ext);
    t = tag_of(op, e);
    @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if ({acc_out, ext_out, skip_pulse, halt_pulse} !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%h acc=%h e=%b: got acc=%h e=%b sk=%b hl=%b, exp acc=%h e=%b sk=%b hl=%b",
               t, op, a, x, acc_out, ext_out, skip_pulse, halt_pulse,
               exp_v[18:3], exp_v[2], exp_v[1], exp_v[0]);
    end
    m_acc = exp_v[18:3];
    m_ext = exp_v[2];
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] pats [4];
    void'($urandom(32'd1234));
    pats[0] = 16'h0000; pats[1] = 16'h8000; pats[2] = 16'h0001; pats[3] = 16'hFFFF;
    // R1: reset state with junk inputs
    en = 1'b1; op_bits = 12'h800; acc_in = 16'hA5A5; ext_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if ({acc_out, ext_out, skip_pulse, halt_pulse} !== 19'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got %h, exp 0", {acc_out, ext_out, skip_pulse, halt_pulse});
    end
    rst = 1'b0; en = 1'b0;
    m_acc = '0; m_ext = 1'b0;
    // directed: every single bit on corner accumulators and both E values
    for (int b = 0; b < 12; b++)
      for (int p = 0; p < 4; p++)
        for (int x = 0; x < 2; x++)
          step(1'b1, 12'(1 << b), pats[p], x[0]);
    // R11: no selector bits, and idle hold
    step(1'b1, 12'h000, 16'h1234, 1'b1);
    step(1'b0, 12'h800, 16'hFFFF, 1'b0);
    step(1'b0, 12'h001, 16'h0000, 1'b1);
    // R10: directed priority cases
    step(1'b1, 12'h801, 16'h4321, 1'b1);
    step(1'b1, 12'h03F, 16'hFFFF, 1'b0);
    step(1'b1, 12'h01F, 16'h0000, 1'b1);
    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [11:0] op;
      case ($urandom_range(0, 3))
        0: op = 12'(1 << $urandom_range(0, 11));
        1: op = 12'($urandom());
        2: op = 12'h000;
        default: op = 12'(1 << $urandom_range(0, 4)) | 12'(1 << $urandom_range(0, 11));
      endcase
      step($urandom_range(0, 5) != 0, op, 16'($urandom()), 1'($urandom()));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule